// File: doc/BRIEF.md
# Preset-Bounded Up/Down Counter with Selectable Count Modes

This block is the counting core of a position-tracking channel. A decoder in front of it sends a one-cycle count strobe together with a direction bit. The block then moves a binary count of `W` bits (24 by default) up or down. A separate preset register holds a boundary value. Depending on the selected mode, the block uses that value as an upper stop, a wrap point or a reload value. The counter itself can only be changed by copying the preset into it. That copy happens either on an explicit load strobe or on an index event when index loading is enabled.

Overflow past the all-ones value sets a sticky carry flag, and underflow below zero sets a sticky borrow flag. Their exclusive OR is an extra count bit, which doubles the range the host can track. A sign flag records the direction of the most recent boundary crossing. A direction flag reports the direction of the last count strobe that was accepted. A flag-clear strobe returns the three wrap flags to zero.

Top module: `modal_preset_counter`

## Requirements
- R1: After reset, the count, the preset register, borrow, carry and sign are all zero, and `dir_up` is 1.
- R2: `preset_wr` stores `preset_din` in the preset register and leaves the count unchanged. `load_req` copies the preset into the count on the next edge and re-enables a stopped counter. A load in the same cycle as a count strobe wins, and that strobe is then ignored.
- R3: When `index_en` is 1, `index_evt` loads the preset like `load_req`. When `index_en` is 0, `index_evt` has no effect on the count.
- R4: With `mode_sel` = 0 (free), each accepted strobe adds or subtracts one. Counting up from all-ones gives 0 and sets carry. Counting down from 0 gives all-ones and sets borrow.
- R5: With `mode_sel` = 1 (limited), an up strobe at count = preset and a down strobe at count = 0 leave the count unchanged and set no flag. A strobe in the opposite direction resumes counting. Otherwise counting follows R4.
- R6: With `mode_sel` = 2 (one-shot), counting follows R4 until a wrap occurs. The wrap takes effect, and all later strobes leave the count unchanged until a load (R2 or R3).
- R7: With `mode_sel` = 3 (modulo), an up strobe at count = preset gives 0 and sets carry. A down strobe at 0 gives the preset and sets borrow. All other strobes step by one without flags, and counting never stops.
- R8: Carry and borrow are sticky, and `ext_bit` equals borrow XOR carry. Sign is set by an underflow event and cleared by an overflow event.
- R9: `clr_flags` clears carry, borrow and sign on the next edge. A wrap event in the same cycle sets its flag anyway.
- R10: `dir_up` takes the value of `cnt_up` from every accepted count strobe (1 = up, 0 = down) and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Count mode: 0 free, 1 limited, 2 one-shot, 3 modulo |
| preset_wr | input | 1 | Write strobe for the preset register |
| preset_din | input | W | Value written to the preset register |
| cnt_en | input | 1 | One-cycle count strobe |
| cnt_up | input | 1 | Direction of the strobe, 1 = up |
| load_req | input | 1 | Copy the preset into the count |
| clr_flags | input | 1 | Clear borrow, carry and sign |
| index_en | input | 1 | Enables loading on index events |
| index_evt | input | 1 | Index event strobe |
| count_q | output | W | Current count |
| borrow_q | output | 1 | Sticky underflow flag |
| carry_q | output | 1 | Sticky overflow flag |
| sign_q | output | 1 | Direction of the last wrap, 1 = underflow |
| ext_bit | output | 1 | Extra count bit, borrow XOR carry |
| dir_up | output | 1 | Direction of the last accepted strobe |

## Verification
The embedded properties check the following on every cycle:
- a load places the previous preset in the count;
- a free-mode wrap from all-ones lands on zero with carry set;
- the limited stop holds the count;
- the modulo up-reload lands on zero;
- a held step leaves the count stable;
- the direction flag follows each accepted strobe;
- the flag-clear and flag-set priority is respected.

Only the bench scenarios can show the longer behaviour. This covers stopping in one-shot mode across many strobes and its release by a load. It also covers resuming after a direction reversal, the sign history over mixed wraps, and agreement with an arithmetic model over every preset value of a narrow instance in all four modes.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_LIMIT   = 2'd1,
    MODE_ONESHOT = 2'd2,
    MODE_MODN    = 2'd3
  } cnt_mode_e;

  typedef struct packed {
    logic wrap_up;
    logic wrap_dn;
    logic hold;
  } step_evt_t;

endpackage

// File: rtl/mpc_preset_store.sv
module mpc_preset_store #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic [W-1:0] preset_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  preset_q <= '0;
    else if (wr) preset_q <= din;
  end

endmodule

// File: rtl/mpc_step_unit.sv
module mpc_step_unit
  import mpc_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] pre,
  input  cnt_mode_e    mode,
  input  logic         up,
  input  logic         stopped,
  output logic [W-1:0] nxt,
  output step_evt_t    evt
);

  // {boundary crossed, stepped value}
  function automatic logic [W:0] bump(input logic [W-1:0] v, input logic go_up);
    logic [W-1:0] r;
    logic         f;
    r = go_up ? v + 1'b1 : v - 1'b1;
    f = go_up ? (&v) : ~(|v);
    return {f, r};
  endfunction

  logic [W:0] plain;
  logic       at_pre;
  logic       at_zero;

  always_comb begin
    plain       = bump(cur, up);
    at_pre      = (cur == pre);
    at_zero     = (cur == '0);
    nxt         = plain[W-1:0];
    evt.wrap_up = up & plain[W];
    evt.wrap_dn = ~up & plain[W];
    evt.hold    = 1'b0;
    unique case (mode)
      MODE_LIMIT: begin
        if ((up && at_pre) || (!up && at_zero)) begin
          nxt = cur;
          evt = '{wrap_up: 1'b0, wrap_dn: 1'b0, hold: 1'b1};
        end
      end
      MODE_ONESHOT: begin
        if (stopped) begin
          nxt = cur;
          evt = '{wrap_up: 1'b0, wrap_dn: 1'b0, hold: 1'b1};
        end
      end
      MODE_MODN: begin
        evt = '0;
        if (up && at_pre) begin
          nxt         = '0;
          evt.wrap_up = 1'b1;
        end else if (!up && at_zero) begin
          nxt         = pre;
          evt.wrap_dn = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mpc_flag_unit.sv
module mpc_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_over,
  input  logic ev_under,
  input  logic clr,
  output logic carry_q,
  output logic borrow_q,
  output logic sign_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
      sign_q   <= 1'b0;
    end else begin
      if (ev_over)  carry_q <= 1'b1;
      else if (clr) carry_q <= 1'b0;
      if (ev_under) borrow_q <= 1'b1;
      else if (clr) borrow_q <= 1'b0;
      if (ev_under)     sign_q <= 1'b1;
      else if (ev_over) sign_q <= 1'b0;
      else if (clr)     sign_q <= 1'b0;
    end
  end

  // R9: a clear without a competing overflow empties carry
  p_clear_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev_over) |=> !carry_q);

  // R9: an underflow beats a clear in the same cycle
  p_under_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_under |=> (borrow_q && sign_q));

  // R8: overflow without underflow leaves sign cleared
  p_over_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_over && !ev_under) |=> (carry_q && !sign_q));

endmodule

// File: rtl/modal_preset_counter.sv
module modal_preset_counter
  import mpc_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_sel,
  input  logic         preset_wr,
  input  logic [W-1:0] preset_din,
  input  logic         cnt_en,
  input  logic         cnt_up,
  input  logic         load_req,
  input  logic         clr_flags,
  input  logic         index_en,
  input  logic         index_evt,
  output logic [W-1:0] count_q,
  output logic         borrow_q,
  output logic         carry_q,
  output logic         sign_q,
  output logic         ext_bit,
  output logic         dir_up
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  cnt_mode_e    mode;
  logic [W-1:0] preset_q;
  logic [W-1:0] step_nxt;
  step_evt_t    step_evt;
  logic         stop_q;

  // named internal events
  logic do_load;
  logic take_step;
  logic ev_over;
  logic ev_under;

  assign mode      = cnt_mode_e'(mode_sel);
  assign do_load   = load_req | (index_en & index_evt);
  assign take_step = cnt_en & ~do_load;
  assign ev_over   = take_step & step_evt.wrap_up;
  assign ev_under  = take_step & step_evt.wrap_dn;
  assign ext_bit   = borrow_q ^ carry_q;

  mpc_preset_store #(.W(W)) u_preset (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (preset_wr),
    .din      (preset_din),
    .preset_q (preset_q)
  );

  mpc_step_unit #(.W(W)) u_step (
    .cur     (count_q),
    .pre     (preset_q),
    .mode    (mode),
    .up      (cnt_up),
    .stopped (stop_q),
    .nxt     (step_nxt),
    .evt     (step_evt)
  );

  mpc_flag_unit u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_over  (ev_over),
    .ev_under (ev_under),
    .clr      (clr_flags),
    .carry_q  (carry_q),
    .borrow_q (borrow_q),
    .sign_q   (sign_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      stop_q  <= 1'b0;
      dir_up  <= 1'b1;
    end else if (do_load) begin
      count_q <= preset_q;
      stop_q  <= 1'b0;
    end else if (take_step) begin
      count_q <= step_nxt;
      dir_up  <= cnt_up;
      if (mode == MODE_ONESHOT && (ev_over || ev_under)) stop_q <= 1'b1;
    end
  end

  // R2: a load places the previous preset value in the count
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> (count_q == $past(preset_q)));

  // R4: free mode wraps from all-ones to zero with carry
  p_free_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_step && mode == MODE_FREE && cnt_up && count_q == ALL_ONES)
      |=> (count_q == '0 && carry_q));

  // R5: an up strobe at the preset in limited mode holds the count
  p_limit_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_step && mode == MODE_LIMIT && cnt_up && count_q == preset_q)
      |=> $stable(count_q));

  // R6: a held step leaves the count unchanged
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_step && step_evt.hold) |=> $stable(count_q));

  // R7: the modulo up-reload lands on zero
  p_modn_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_step && mode == MODE_MODN && cnt_up && count_q == preset_q)
      |=> (count_q == '0));

  // R10: the direction flag follows each accepted strobe
  p_dir_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_step |=> (dir_up == $past(cnt_up)));

endmodule

// File: tb/modal_preset_counter_bench.sv
module modal_preset_counter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode_sel = 2'd0;
  logic         preset_wr = 1'b0;
  logic [W-1:0] preset_din = '0;
  logic         cnt_en = 1'b0;
  logic         cnt_up = 1'b0;
  logic         load_req = 1'b0;
  logic         clr_flags = 1'b0;
  logic         index_en = 1'b0;
  logic         index_evt = 1'b0;
  logic [W-1:0] count_q;
  logic         borrow_q, carry_q, sign_q, ext_bit, dir_up;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  int m_cnt, m_pre;
  bit m_stop, m_car, m_bor, m_sgn, m_dir;

  always #(CLK_PERIOD/2) clk = ~clk;

  modal_preset_counter #(.W(W)) u_modal_preset_counter (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .preset_wr(preset_wr),
    .preset_din(preset_din), .cnt_en(cnt_en), .cnt_up(cnt_up),
    .load_req(load_req), .clr_flags(clr_flags), .index_en(index_en),
    .index_evt(index_evt), .count_q(count_q), .borrow_q(borrow_q),
    .carry_q(carry_q), .sign_q(sign_q), .ext_bit(ext_bit), .dir_up(dir_up)
  );

  task automatic compare(input string tag);
    bit ok;
    ok = (int'(count_q) == m_cnt) && (carry_q == m_car) && (borrow_q == m_bor) &&
         (sign_q == m_sgn) && (ext_bit == (m_car ^ m_bor)) && (dir_up == m_dir);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s mode=%0d actual cnt=%0d c=%0b b=%0b s=%0b x=%0b d=%0b expected cnt=%0d c=%0b b=%0b s=%0b x=%0b d=%0b",
               tag, mode_sel, count_q, carry_q, borrow_q, sign_q, ext_bit, dir_up,
               m_cnt, m_car, m_bor, m_sgn, m_car ^ m_bor, m_dir);
    end
  endtask

  // one clock with the given stimulus, then model update and check
  task automatic cyc(input string tag, input bit en, input bit up, input bit ld,
                     input bit clr, input bit ie, input bit ix, input bit wr, input int data);
    bit ov, un;
    cnt_en = en; cnt_up = up; load_req = ld; clr_flags = clr;
    index_en = ie; index_evt = ix; preset_wr = wr; preset_din = data[W-1:0];
    @(posedge clk);
    #1;
    ov = 0; un = 0;
    if (ld || (ie && ix)) begin
      m_cnt = m_pre; m_stop = 0;
    end else if (en) begin
      m_dir = up;
      case (int'(mode_sel))
        1: begin
          if (up && m_cnt == m_pre) ;
          else if (!up && m_cnt == 0) ;
          else if (up) begin ov = (m_cnt == MAXV); m_cnt = (m_cnt + 1) % (MAXV + 1); end
          else begin un = (m_cnt == 0); m_cnt = (m_cnt + MAXV) % (MAXV + 1); end
        end
        3: begin
          if (up) begin
            if (m_cnt == m_pre) begin m_cnt = 0; ov = 1; end
            else m_cnt = (m_cnt + 1) % (MAXV + 1);
          end else begin
            if (m_cnt == 0) begin m_cnt = m_pre; un = 1; end
            else m_cnt = m_cnt - 1;
          end
        end
        default: begin
          if (!(mode_sel == 2 && m_stop)) begin
            if (up) begin ov = (m_cnt == MAXV); m_cnt = (m_cnt + 1) % (MAXV + 1); end
            else begin un = (m_cnt == 0); m_cnt = (m_cnt + MAXV) % (MAXV + 1); end
            if (mode_sel == 2 && (ov || un)) m_stop = 1;
          end
        end
      endcase
    end
    if (ov) m_car = 1; else if (clr) m_car = 0;
    if (un) m_bor = 1; else if (clr) m_bor = 0;
    if (un) m_sgn = 1; else if (ov) m_sgn = 0; else if (clr) m_sgn = 0;
    if (wr) m_pre = data;
    cnt_en = 0; load_req = 0; clr_flags = 0; index_en = 0; index_evt = 0; preset_wr = 0;
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string mtag [4];
    mtag[0] = "R4"; mtag[1] = "R5"; mtag[2] = "R6"; mtag[3] = "R7";
    m_cnt = 0; m_pre = 0; m_stop = 0; m_car = 0; m_bor = 0; m_sgn = 0; m_dir = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    compare("R1");
    cyc("R1", 0, 0, 1, 0, 0, 0, 0, 0);      // load of reset preset gives 0

    // R2: preset write leaves count; load copies; load beats strobe
    cyc("R2", 0, 0, 0, 0, 0, 0, 1, 9);
    cyc("R2", 0, 0, 1, 0, 0, 0, 0, 0);
    cyc("R2", 1, 1, 0, 0, 0, 0, 0, 0);
    cyc("R2", 1, 0, 1, 0, 0, 0, 0, 0);

    // R3: index ignored when disabled, loads when enabled
    cyc("R3", 1, 1, 0, 0, 0, 0, 0, 0);
    cyc("R3", 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R3", 0, 0, 0, 0, 1, 1, 0, 0);

    // R10: direction follows accepted strobes
    cyc("R10", 1, 0, 0, 0, 0, 0, 0, 0);
    cyc("R10", 0, 1, 0, 0, 0, 0, 0, 0);
    cyc("R10", 1, 1, 0, 0, 0, 0, 0, 0);

    // R8: underflow then overflow in free mode
    mode_sel = 2'd0;
    cyc("R8", 0, 0, 0, 1, 0, 0, 1, 0);
    cyc("R8", 0, 0, 1, 0, 0, 0, 0, 0);
    cyc("R8", 1, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < MAXV + 1; i++) cyc("R8", 1, 1, 0, 0, 0, 0, 0, 0);

    // R9: clear with same-cycle wrap, then plain clear
    cyc("R9", 0, 0, 0, 1, 0, 0, 1, MAXV);
    cyc("R9", 0, 0, 1, 0, 0, 0, 0, 0);
    cyc("R9", 1, 1, 0, 1, 0, 0, 0, 0);
    cyc("R9", 0, 0, 0, 1, 0, 0, 0, 0);

    // sweep every mode over every preset value
    for (int md = 0; md < 4; md++) begin
      mode_sel = md[1:0];
      for (int p = 0; p <= MAXV; p++) begin
        cyc(mtag[md], 0, 0, 0, 1, 0, 0, 1, p);
        cyc(mtag[md], 0, 0, 1, 0, 0, 0, 0, 0);
        for (int k = 0; k < MAXV + 5; k++) cyc(mtag[md], 1, 1, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 2 * MAXV + 4; k++) cyc(mtag[md], 1, 0, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) cyc(mtag[md], 1, 1, 0, 0, 0, 0, 0, 0);
        cyc(mtag[md], 0, 0, 0, 0, 1, 1, 0, 0);   // index reload releases a stop
        cyc(mtag[md], 1, 0, 0, 0, 0, 0, 0, 0);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule